// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. It holds a fixed 4,608-bit storage array. A parameter divides that array between depth and width in one of five shapes. A producer pushes words on the write clock. A consumer pulls words on the read clock. Each side sees flags computed in its own clock domain: the write side gets full and almost-full, and the read side gets empty and almost-empty.

Each side keeps a binary pointer one bit wider than the address. It sends a Gray-coded copy of that pointer to the other side through a chain of two flip-flops, and converts what it receives back to binary to compute its view of the occupancy. Because the pointer arrives late, each side sees a stale value. Full and empty therefore release late, but they never release early.

Each side has a small level machine that holds its flags. The write-side machine has the states WS_ROOM, WS_NEAR and WS_FULL. The read-side machine has the states RS_EMPTY, RS_LOW and RS_AVAIL. On every clock edge, the machine moves to the state that matches the occupancy that results after that edge's operation:
- The write side goes to WS_FULL when the occupancy equals the depth.
- Otherwise it goes to WS_NEAR when the occupancy is at or above the almost-full level.
- Otherwise it goes to WS_ROOM.
- The read side goes to RS_EMPTY when the occupancy is zero.
- Otherwise it goes to RS_LOW when the occupancy is at or below the almost-empty level.
- Otherwise it goes to RS_AVAIL.

Any state can move to any other state of the same side in a single edge. Reset puts the write side in WS_ROOM and the read side in RS_EMPTY. The two level inputs are sampled on every edge, so software-free logic may change them while data is flowing.

Top module: `xclk_fifo`

## Requirements
- R1: Parameter SHAPE selects the width and depth: 0 gives 4096x1, 1 gives 2048x2, 2 gives 1024x4, 3 gives 512x9 and 4 gives 256x18. With the default shape 3, data is 9 bits wide and full rises on exactly the 512th unread write.
- R2: Words are read out in the order they were written, with their values unchanged.
- R3: Full is produced on the write clock. It is high after the write edge that makes the write-side occupancy equal the depth. A write while full is high is dropped: it does not move the write pointer and does not store anything.
- R4: Empty is produced on the read clock. It is high out of reset and whenever the read-side occupancy is zero. A read while empty is high is dropped: it does not move the read pointer and does not change the read data.
- R5: Almost-full is high when the write-side occupancy is greater than or equal to the almost-full level, and it is always high while full is high.
- R6: Almost-empty is high when the read-side occupancy is less than or equal to the almost-empty level, and it is always high while empty is high.
- R7: Read data is registered. It takes the head word on the read edge that accepts a read, and it holds its value on every other read edge.
- R8: After reset, empty and almost-empty are high, full is low, and almost-full is low for a nonzero almost-full level.
- R9: A change of either level input takes effect on the flag within a few edges of that flag's clock, with no data movement needed.
- R10: Flags are pessimistic. Empty stays high for at least two read edges after the first write into an empty buffer. Full stays high for at least two write edges after a read from a full buffer. Each Gray pointer changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, rising edge |
| wr_rst_n | input | 1 | Active-low reset for the write domain |
| wr_en | input | 1 | Push request |
| wr_data | input | DW | Word to push |
| full | output | 1 | Buffer full (write domain) |
| almost_full | output | 1 | Occupancy at or above af_level (write domain) |
| af_level | input | AW+1 | Almost-full level |
| rd_clk | input | 1 | Read clock, rising edge |
| rd_rst_n | input | 1 | Active-low reset for the read domain |
| rd_en | input | 1 | Pop request |
| rd_data | output | DW | Registered head word |
| empty | output | 1 | Buffer empty (read domain) |
| almost_empty | output | 1 | Occupancy at or below ae_level (read domain) |
| ae_level | input | AW+1 | Almost-empty level |

## Verification
A short table of eight irregular words is pushed and then drained. This separates correct ordering and correct data from stuck or swapped bits, and it shows the almost-empty edge as the occupancy drops to the level. A full fill with an arithmetic pattern shows that full rises at exactly the depth. Followed by a push while full, it shows that the extra word is never stored, because the drain must end empty after exactly the depth reads. Pops on an empty buffer, level changes while no data moves, and flag samples taken one edge after the opposite side acts separate dropped-request handling, run-time thresholds and pessimistic release from an early or optimistic design.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

    localparam int ARRAY_BITS = 4608;

    function automatic int shape_width(input int shape);
        case (shape)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 9;
            default: return 18;
        endcase
    endfunction

    function automatic int shape_depth(input int shape);
        case (shape)
            0:       return 4096;
            1:       return 2048;
            2:       return 1024;
            3:       return 512;
            default: return 256;
        endcase
    endfunction

    typedef enum logic [1:0] {
        WS_ROOM = 2'd0,
        WS_NEAR = 2'd1,
        WS_FULL = 2'd2
    } wr_level_e;

    typedef enum logic [1:0] {
        RS_EMPTY = 2'd0,
        RS_LOW   = 2'd1,
        RS_AVAIL = 2'd2
    } rd_level_e;

endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem #(
    parameter int DW = 9,
    parameter int AW = 9,
    localparam int DEPTH = 1 << AW
) (
    input  logic          wr_clk,
    input  logic          wr_fire,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_fire,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_fire) store[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n)    rdata <= '0;
        else if (rd_fire) rdata <= store[raddr];
    end

    AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_fire |=> $stable(rdata)); // R7

endmodule

// File: rtl/xclk_fifo_wctl.sv
module xclk_fifo_wctl
    import xclk_fifo_pkg::*;
#(
    parameter int AW = 9,
    localparam int PW = AW + 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_seen,
    input  logic [PW-1:0] af_level,
    output logic          wr_fire,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          almost_full
);

    wr_level_e     lvl_q, lvl_d;
    logic [PW-1:0] wbin, wbin_nxt, rbin_seen, occ_nxt, occ_now;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin_seen[i] = ^(rgray_seen >> i);
    end

    assign wr_fire  = wr_en && (lvl_q != WS_FULL);
    assign wbin_nxt = wbin + PW'(wr_fire);
    assign occ_nxt  = wbin_nxt - rbin_seen;
    assign occ_now  = wbin - rbin_seen;
    assign waddr    = wbin[AW-1:0];

    always_comb begin
        if (occ_nxt == PW'(DEPTH))   lvl_d = WS_FULL;
        else if (occ_nxt >= af_level) lvl_d = WS_NEAR;
        else                          lvl_d = WS_ROOM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= WS_ROOM;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            lvl_q <= lvl_d;
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    always_comb begin
        unique case (lvl_q)
            WS_ROOM: begin full = 1'b0; almost_full = 1'b0; end
            WS_NEAR: begin full = 1'b0; almost_full = 1'b1; end
            WS_FULL: begin full = 1'b1; almost_full = 1'b1; end
            default: begin full = 1'b0; almost_full = 1'b0; end
        endcase
    end

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wbin)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_now <= PW'(DEPTH)); // R3
    AST_FULL_HAS_AF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full); // R5
    AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R10

endmodule

// File: rtl/xclk_fifo_rctl.sv
module xclk_fifo_rctl
    import xclk_fifo_pkg::*;
#(
    parameter int AW = 9,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_seen,
    input  logic [PW-1:0] ae_level,
    output logic          rd_fire,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          empty,
    output logic          almost_empty
);

    rd_level_e     lvl_q, lvl_d;
    logic [PW-1:0] rbin, rbin_nxt, wbin_seen, occ_nxt;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_seen[i] = ^(wgray_seen >> i);
    end

    assign rd_fire  = rd_en && (lvl_q != RS_EMPTY);
    assign rbin_nxt = rbin + PW'(rd_fire);
    assign occ_nxt  = wbin_seen - rbin_nxt;
    assign raddr    = rbin[AW-1:0];

    always_comb begin
        if (occ_nxt == '0)            lvl_d = RS_EMPTY;
        else if (occ_nxt <= ae_level) lvl_d = RS_LOW;
        else                          lvl_d = RS_AVAIL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= RS_EMPTY;
            rbin  <= '0;
            rgray <= '0;
        end else begin
            lvl_q <= lvl_d;
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    always_comb begin
        unique case (lvl_q)
            RS_EMPTY: begin empty = 1'b1; almost_empty = 1'b1; end
            RS_LOW:   begin empty = 1'b0; almost_empty = 1'b1; end
            RS_AVAIL: begin empty = 1'b0; almost_empty = 1'b0; end
            default:  begin empty = 1'b1; almost_empty = 1'b1; end
        endcase
    end

    AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> $stable(rbin)); // R4
    AST_EMPTY_HAS_AE: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty); // R6
    AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1); // R10

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int SHAPE = 3,
    localparam int DW = shape_width(SHAPE),
    localparam int DEPTH = shape_depth(SHAPE),
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic          almost_full,
    input  logic [PW-1:0] af_level,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          almost_empty,
    input  logic [PW-1:0] ae_level
);

    logic          wr_fire, rd_fire;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_seen, rgray_seen;

    xclk_fifo_wctl #(.AW(AW)) u_wctl (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .wr_en       (wr_en),
        .rgray_seen  (rgray_seen),
        .af_level    (af_level),
        .wr_fire     (wr_fire),
        .waddr       (waddr),
        .wgray       (wgray),
        .full        (full),
        .almost_full (almost_full)
    );

    xclk_fifo_rctl #(.AW(AW)) u_rctl (
        .clk          (rd_clk),
        .rst_n        (rd_rst_n),
        .rd_en        (rd_en),
        .wgray_seen   (wgray_seen),
        .ae_level     (ae_level),
        .rd_fire      (rd_fire),
        .raddr        (raddr),
        .rgray        (rgray),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    xclk_fifo_sync #(.W(PW), .STAGES(2)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_seen)
    );

    xclk_fifo_sync #(.W(PW), .STAGES(2)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_seen)
    );

    xclk_fifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wr_clk   (wr_clk),
        .wr_fire  (wr_fire),
        .waddr    (waddr),
        .wdata    (wr_data),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_fire  (rd_fire),
        .raddr    (raddr),
        .rdata    (rd_data)
    );

endmodule

// File: tb/xclk_fifo_test.sv
`timescale 1ns/1ps
module xclk_fifo_test;

    localparam int DW = 9;
    localparam int DEPTH = 512;
    localparam int PW = 10;
    localparam logic [DW-1:0] VEC [8] = '{9'h155, 9'h0AA, 9'h1FF, 9'h000,
                                          9'h123, 9'h0F0, 9'h10F, 9'h081};

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst_n = 0, rd_rst_n = 0;
    logic          wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [PW-1:0] af_level = 10'd500, ae_level = 10'd2;
    logic          full, almost_full, empty, almost_empty;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    xclk_fifo uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .almost_full(almost_full), .af_level(af_level),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty), .ae_level(ae_level)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read();
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge wr_clk);
        repeat (5) @(negedge rd_clk);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 7 + 3) % DEPTH);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge wr_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        settle();
        // R8 reset state
        check("R8 empty", empty, 1);
        check("R8 almost_empty", almost_empty, 1);
        check("R8 full", full, 0);
        check("R8 almost_full", almost_full, 0);
        check("R1 width", $bits(rd_data), DW);

        // table walk
        for (int i = 0; i < 8; i++) begin
            do_write(VEC[i]);
            if (i == 0) begin
                @(negedge rd_clk);
                check("R10 empty late", empty, 1);
            end
        end
        settle();
        check("R4 not empty", empty, 0);
        check("R6 ae low at 8", almost_empty, 0);
        for (int i = 0; i < 8; i++) begin
            do_read();
            check("R2 table order", rd_data, VEC[i]);
            if (i == 0) begin
                repeat (3) @(negedge rd_clk);
                check("R7 hold idle", rd_data, VEC[0]);
            end
            if (i == 5) begin
                settle();
                check("R6 ae at level", almost_empty, 1);
                check("R6 not empty", empty, 0);
            end
        end
        settle();
        check("R4 empty drained", empty, 1);
        do_read();
        check("R4 read on empty data", rd_data, VEC[7]);
        check("R4 still empty", empty, 1);

        // fill
        for (int i = 0; i < 499; i++) do_write(pat(i));
        settle();
        check("R5 below level", almost_full, 0);
        do_write(pat(499));
        settle();
        check("R5 at level", almost_full, 1);
        af_level = 10'd510;
        ae_level = 10'd600;
        settle();
        check("R9 af new level", almost_full, 0);
        check("R9 ae new level", almost_empty, 1);
        af_level = 10'd500;
        ae_level = 10'd2;
        settle();
        check("R9 af restored", almost_full, 1);
        check("R9 ae restored", almost_empty, 0);
        for (int i = 500; i < 511; i++) do_write(pat(i));
        settle();
        check("R1 not full at depth-1", full, 0);
        do_write(pat(511));
        check("R3 full at depth", full, 1);
        check("R5 af with full", almost_full, 1);
        do_write(9'h1FF);
        settle();
        check("R3 full held", full, 1);
        do_read();
        check("R2 fill first", rd_data, pat(0));
        @(negedge wr_clk);
        check("R10 full late", full, 1);
        for (int i = 1; i < DEPTH; i++) begin
            do_read();
            check("R2 fill order", rd_data, pat(i));
        end
        settle();
        check("R3 dropped write not stored", empty, 1);
        check("R6 ae when empty", almost_empty, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule